// File: doc/BRIEF.md
# Flash Request Chunking Sequencer

This block sits between a requester and a single-cycle flash command engine. The requester hands over one long request: an operation, a start address and a length in bytes. The block turns it into a series of commands that the engine can execute one at a time. It offers each command on a valid/ready port and then waits for a done-or-error response before it offers the next command.

Read and write requests are cut into chunks. Each chunk fits the engine's 64-byte data buffer and never crosses a 256-byte page. Erase requests are cut into 64 KiB block erases wherever alignment and the remaining length allow, and into 4 KiB sector erases elsewhere. A status request becomes a single one-byte command. The block reports the outcome as a one-cycle completion pulse that carries a result code: success, hardware error (the first error response stops the sequence), or argument error (a misaligned erase).

Top module: `fseq_chunker`

## Requirements
- R1: A request with req_op 0 (read) or 1 (write) issues chunks whose byte count is the smallest of three values: the remaining length, 64, and the bytes left up to the next 256-byte boundary. The command cycle code is 0 for read and 2 for write. cmd_cnt carries the byte count minus one.
- R2: An erase request (req_op 2) whose address or length is not a multiple of 4096 completes with code 2 (argument error) and issues no command.
- R3: Each erase step uses cycle code 4 (64 KiB erase) when the current address is 65536-aligned and at least 65536 bytes remain, and cycle code 3 (4 KiB erase) otherwise. Erase commands carry cmd_cnt 0.
- R4: After each successful response, the address advances and the remaining length shrinks by the chunk size. When the remaining length reaches zero, the request completes with code 0 (success).
- R5: An error response (rsp_valid with rsp_err) ends the request at once with code 1. No further command is issued for that request.
- R6: A status request (req_op 3) issues exactly one command with address 0, cycle code 8 and cmd_cnt 0, whatever req_addr and req_len are.
- R7: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_addr, cmd_cycle and cmd_cnt hold their values.
- R8: A read or write request of length zero, and an aligned erase of length zero, complete with code 0 and issue no command.
- R9: Completion is signalled by done_pulse, high for one cycle, with done_code in the same cycle. The pulse comes in the cycle after the final response is sampled, or in the cycle after acceptance for a request that issues no command. done_code never takes the value 3.
- R10: A request is accepted only on a clock edge where busy is low. busy is high from the cycle after the acceptance of a command-issuing request until the completion pulse, and it is low in the pulse cycle. req_valid is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2 | 0 read, 1 write, 2 erase, 3 status |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| busy | output | 1 | A request is in progress |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_addr | output | ADDR_W | Command address |
| cmd_cycle | output | 4 | Cycle code: 0 read, 2 write, 3 4 KiB erase, 4 64 KiB erase, 8 status |
| cmd_cnt | output | $clog2(BUF_BYTES) | Byte count minus one |
| rsp_valid | input | 1 | Engine finished the last command |
| rsp_err | input | 1 | That command failed |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_code | output | 2 | 0 success, 1 hardware error, 2 argument error |

## Verification
Some properties can be checked on every cycle from the command port alone. These are: command values hold under back-pressure, no read or write command crosses a page, every 64 KiB erase is block-aligned and every erase is sector-aligned, the error response leads to code 1 in the next cycle, and a command is only offered while busy. The full chunk sequence can only be shown by the bench scenarios, which compare every issued command against an independently computed list. That sequence covers the mix of 4 KiB and 64 KiB erases, the advance of the address and remaining length, the total number of commands, the truncation after an injected error, and the fact that a request offered while busy has no effect.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        OP_RD = 2'd0,
        OP_WR = 2'd1,
        OP_ER = 2'd2,
        OP_ST = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } st_e;

    // cycle codes decoded by the downstream command engine
    localparam logic [3:0] CYC_RD   = 4'd0;
    localparam logic [3:0] CYC_WR   = 4'd2;
    localparam logic [3:0] CYC_E4K  = 4'd3;
    localparam logic [3:0] CYC_E64K = 4'd4;
    localparam logic [3:0] CYC_STAT = 4'd8;

    localparam logic [1:0] RES_OK    = 2'd0;
    localparam logic [1:0] RES_HWERR = 2'd1;
    localparam logic [1:0] RES_ARG   = 2'd2;

endpackage

// File: rtl/fseq_rw_chunk.sv
// Size of the next read/write chunk: min(remaining, buffer, bytes to page end)
module fseq_rw_chunk #(
    parameter int LEN_W      = 32,
    parameter int BUF_BYTES  = 64,
    parameter int PAGE_BYTES = 256,
    localparam int PG_W      = $clog2(PAGE_BYTES)
) (
    input  logic [PG_W-1:0]  page_off,
    input  logic [LEN_W-1:0] rem,
    output logic [LEN_W-1:0] bytes
);
    logic [LEN_W-1:0] to_page;
    logic [LEN_W-1:0] lim;

    assign to_page = LEN_W'(PAGE_BYTES) - LEN_W'(page_off);

    generate
        if (BUF_BYTES >= PAGE_BYTES) begin : g_page_bound
            // the page is never larger than the buffer: page end is the limit
            assign lim = to_page;
        end else begin : g_both_bound
            assign lim = (LEN_W'(BUF_BYTES) < to_page) ? LEN_W'(BUF_BYTES) : to_page;
        end
    endgenerate

    assign bytes = (rem < lim) ? rem : lim;

endmodule

// File: rtl/fseq_erase_step.sv
// Picks block or sector erase for the current position
module fseq_erase_step #(
    parameter int LEN_W        = 32,
    parameter int SECTOR_BYTES = 4096,
    parameter int BLOCK_BYTES  = 65536,
    localparam int BLK_W       = $clog2(BLOCK_BYTES)
) (
    input  logic [BLK_W-1:0] blk_off,
    input  logic [LEN_W-1:0] rem,
    output logic             use_blk,
    output logic [LEN_W-1:0] bytes
);
    assign use_blk = (blk_off == '0) && (rem >= LEN_W'(BLOCK_BYTES));
    assign bytes   = use_blk ? LEN_W'(BLOCK_BYTES) : LEN_W'(SECTOR_BYTES);

endmodule

// File: rtl/fseq_req_check.sv
// Classifies a new request: needs commands, or completes at once with a code
module fseq_req_check
    import fseq_pkg::*;
#(
    parameter int LEN_W        = 32,
    parameter int SECTOR_BYTES = 4096,
    localparam int SEC_W       = $clog2(SECTOR_BYTES)
) (
    input  op_e              op,
    input  logic [SEC_W-1:0] sec_off,
    input  logic [LEN_W-1:0] len,
    output logic             imm,
    output logic [1:0]       imm_code
);
    always_comb begin
        imm      = 1'b0;
        imm_code = RES_OK;
        case (op)
            OP_RD, OP_WR: begin
                imm = (len == '0);
            end
            OP_ER: begin
                if ((sec_off != '0) || (len[SEC_W-1:0] != '0)) begin
                    imm      = 1'b1;
                    imm_code = RES_ARG;
                end else begin
                    imm = (len == '0);
                end
            end
            default: begin
                imm = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fseq_chunker.sv
module fseq_chunker
    import fseq_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int LEN_W        = 32,
    parameter int BUF_BYTES    = 64,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096,
    parameter int BLOCK_BYTES  = 65536,
    localparam int CNT_W       = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [3:0]        cmd_cycle,
    output logic [CNT_W-1:0]  cmd_cnt,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    output logic              done_pulse,
    output logic [1:0]        done_code
);
    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int SEC_W = $clog2(SECTOR_BYTES);
    localparam int BLK_W = $clog2(BLOCK_BYTES);

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic              done;
        logic [1:0]        code;
    } seq_t;

    seq_t q, d;

    op_e              op_in;
    logic             imm;
    logic [1:0]       imm_code;
    logic [LEN_W-1:0] rw_bytes;
    logic [LEN_W-1:0] er_bytes;
    logic             er_blk;
    logic [LEN_W-1:0] step;

    assign op_in = op_e'(req_op);

    fseq_req_check #(
        .LEN_W        (LEN_W),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_check (
        .op       (op_in),
        .sec_off  (req_addr[SEC_W-1:0]),
        .len      (req_len),
        .imm      (imm),
        .imm_code (imm_code)
    );

    fseq_rw_chunk #(
        .LEN_W      (LEN_W),
        .BUF_BYTES  (BUF_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_rw (
        .page_off (q.addr[PG_W-1:0]),
        .rem      (q.rem),
        .bytes    (rw_bytes)
    );

    fseq_erase_step #(
        .LEN_W        (LEN_W),
        .SECTOR_BYTES (SECTOR_BYTES),
        .BLOCK_BYTES  (BLOCK_BYTES)
    ) u_er (
        .blk_off (q.addr[BLK_W-1:0]),
        .rem     (q.rem),
        .use_blk (er_blk),
        .bytes   (er_bytes)
    );

    always_comb begin
        case (q.op)
            OP_ER:   step = er_bytes;
            OP_ST:   step = LEN_W'(1);
            default: step = rw_bytes;
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if (imm) begin
                        d.done = 1'b1;
                        d.code = imm_code;
                    end else begin
                        d.st   = S_ISSUE;
                        d.op   = op_in;
                        d.addr = (op_in == OP_ST) ? '0 : req_addr;
                        d.rem  = (op_in == OP_ST) ? LEN_W'(1) : req_len;
                    end
                end
            end
            S_ISSUE: begin
                if (cmd_ready) begin
                    d.st = S_WAIT;
                end
            end
            S_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_err) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.code = RES_HWERR;
                    end else begin
                        d.addr = q.addr + ADDR_W'(step);
                        d.rem  = q.rem - step;
                        if (q.rem == step) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                            d.code = RES_OK;
                        end else begin
                            d.st = S_ISSUE;
                        end
                    end
                end
            end
            default: begin
                d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != S_IDLE);
    assign cmd_valid  = (q.st == S_ISSUE);
    assign cmd_addr   = q.addr;
    assign done_pulse = q.done;
    assign done_code  = q.code;

    always_comb begin
        case (q.op)
            OP_RD:   cmd_cycle = CYC_RD;
            OP_WR:   cmd_cycle = CYC_WR;
            OP_ER:   cmd_cycle = er_blk ? CYC_E64K : CYC_E4K;
            default: cmd_cycle = CYC_STAT;
        endcase
    end

    assign cmd_cnt = ((q.op == OP_RD) || (q.op == OP_WR)) ? CNT_W'(rw_bytes - LEN_W'(1)) : '0;

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                       && $stable(cmd_cycle) && $stable(cmd_cnt)));

    // R1
    page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ((cmd_cycle == CYC_RD) || (cmd_cycle == CYC_WR)))
        |-> ((32'(cmd_addr[PG_W-1:0]) + 32'(cmd_cnt)) < 32'(PAGE_BYTES)));

    // R3
    block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_cycle == CYC_E64K)) |-> (cmd_addr[BLK_W-1:0] == '0));

    // R3
    sector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_cycle == CYC_E4K)) |-> (cmd_addr[SEC_W-1:0] == '0));

    // R5
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_valid && rsp_valid && rsp_err)
        |=> (done_pulse && (done_code == RES_HWERR) && !cmd_valid));

    // R10
    cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    // R9
    done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> ((done_code != 2'd3) && !busy));

endmodule

// File: tb/sim_fseq_chunker.sv
module sim_fseq_chunker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_len = '0;
    logic        busy;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic [3:0]  cmd_cycle;
    logic [5:0]  cmd_cnt;
    logic        rsp_valid = 1'b0;
    logic        rsp_err = 1'b0;
    logic        done_pulse;
    logic [1:0]  done_code;

    int total = 0;
    int bad = 0;

    logic [41:0] exp_q[$];
    logic [1:0]  code_q[$];
    string       cur_tag = "R1";
    int          err_at = -1;
    int          cmd_idx = 0;
    bit          done_seen = 1'b0;

    always #10 clk = ~clk;

    fseq_chunker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_cycle(cmd_cycle), .cmd_cnt(cmd_cnt), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .done_pulse(done_pulse), .done_code(done_code)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor and command engine model
    initial begin
        logic [41:0] cap;
        logic [41:0] first;
        logic [41:0] e;
        bit   seen = 1'b0;
        bit   prev_done = 1'b0;
        int   pend = 0;
        int   stall = 0;
        forever begin
            @(negedge clk);
            if (rsp_valid) rsp_valid = 1'b0;
            if (prev_done) chk(!done_pulse, "R9 pulse width", 64'(done_pulse), 64'd0);
            prev_done = done_pulse;
            if (done_pulse) begin
                if (code_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected completion", 64'(done_code), 64'd0);
                end else begin
                    chk(done_code == code_q[0], {cur_tag, " result code"}, 64'(done_code), 64'(code_q[0]));
                    void'(code_q.pop_front());
                end
                chk(exp_q.size() == 0, {cur_tag, " commands missing"}, 64'(exp_q.size()), 64'd0);
                exp_q.delete();
                done_seen = 1'b1;
            end
            if (cmd_ready) begin
                cmd_ready = 1'b0;
                seen = 1'b0;
                // R7: value at handshake equals value first offered
                chk(cap == first, "R7 hold under stall", 64'(cap), 64'(first));
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_tag, " extra command"}, 64'(cap), 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk(cap == e, {cur_tag, " command addr/cycle/cnt"}, 64'(cap), 64'(e));
                end
                pend = 1 + (cmd_idx % 3);
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rsp_valid = 1'b1;
                    rsp_err = (cmd_idx == err_at);
                    cmd_idx++;
                end
            end else if (cmd_valid) begin
                if (!seen) begin
                    seen = 1'b1;
                    first = {cmd_addr, cmd_cycle, cmd_cnt};
                    stall = 0;
                end
                if (stall >= (cmd_idx % 3)) begin
                    cmd_ready = 1'b1;
                    cap = {cmd_addr, cmd_cycle, cmd_cnt};
                end else begin
                    stall++;
                end
            end
        end
    end

    task automatic run_req(input logic [1:0] op, input logic [31:0] a, input logic [31:0] l,
                           input int err, input bit poke, input string tag);
        logic [31:0] ca;
        logic [31:0] cr;
        logic [31:0] c;
        logic [31:0] pg;
        logic [1:0]  code;
        int n;
        ca = a; cr = l; n = 0; code = 2'd0;
        if (op == 2'd2 && (a[11:0] != 0 || l[11:0] != 0)) begin
            code = 2'd2;
        end else if (op == 2'd3) begin
            exp_q.push_back({32'd0, 4'd8, 6'd0});
            n = 1;
        end else if (op == 2'd2) begin
            while (cr != 0) begin
                if (ca[15:0] == 0 && cr >= 32'h10000) begin
                    exp_q.push_back({ca, 4'd4, 6'd0}); c = 32'h10000;
                end else begin
                    exp_q.push_back({ca, 4'd3, 6'd0}); c = 32'h1000;
                end
                ca += c; cr -= c; n++;
            end
        end else begin
            while (cr != 0) begin
                c = (cr < 64) ? cr : 32'd64;
                pg = 32'd256 - {24'd0, ca[7:0]};
                if (c > pg) c = pg;
                exp_q.push_back({ca, (op == 2'd0) ? 4'd0 : 4'd2, 6'(c - 1)});
                ca += c; cr -= c; n++;
            end
        end
        if (err >= 0 && err < n) begin
            while (exp_q.size() > err + 1) void'(exp_q.pop_back());
            code = 2'd1;
        end
        code_q.push_back(code);
        cur_tag = tag; err_at = err; cmd_idx = 0; done_seen = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
        if (n > 0 && code != 2'd2)
            chk(busy == 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
        else
            chk(busy == 1'b0, "R10 no busy for immediate", 64'(busy), 64'd0);
        if (poke) begin
            @(negedge clk);
            // R10: offered while busy, must be ignored
            req_valid = 1'b1; req_op = 2'd3; req_addr = 32'h40; req_len = 32'd8;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done_seen) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R10 reset busy", 64'(busy), 64'd0);
        chk(cmd_valid == 1'b0, "R7 reset cmd_valid", 64'(cmd_valid), 64'd0);
        chk(done_pulse == 1'b0, "R9 reset done", 64'(done_pulse), 64'd0);

        run_req(2'd0, 32'h0000_0010, 32'd300, -1, 1'b0, "R1 R4 read");
        run_req(2'd1, 32'h0000_00F0, 32'd20, -1, 1'b0, "R1 write page");
        run_req(2'd0, 32'h0000_0100, 32'd64, -1, 1'b0, "R1 single chunk");
        run_req(2'd0, 32'h0000_03FF, 32'd3, -1, 1'b0, "R1 one byte to page");
        run_req(2'd2, 32'h0001_F000, 32'h0002_2000, -1, 1'b0, "R3 R4 erase mix");
        run_req(2'd2, 32'h0002_0000, 32'h0001_0000, -1, 1'b0, "R3 block erase");
        run_req(2'd2, 32'h0000_1800, 32'h0000_1000, -1, 1'b0, "R2 misaligned addr");
        run_req(2'd2, 32'h0000_1000, 32'h0000_1800, -1, 1'b0, "R2 misaligned len");
        run_req(2'd3, 32'h1234_5678, 32'd77, -1, 1'b0, "R6 status");
        run_req(2'd0, 32'h0000_0040, 32'd0, -1, 1'b0, "R8 zero read");
        run_req(2'd1, 32'h0000_0040, 32'd0, -1, 1'b0, "R8 zero write");
        run_req(2'd2, 32'h0000_0000, 32'd0, -1, 1'b0, "R8 zero erase");
        run_req(2'd1, 32'h0000_0000, 32'd200, 2, 1'b0, "R5 write error");
        run_req(2'd2, 32'h0001_0000, 32'h0002_0000, 0, 1'b0, "R5 erase error");
        run_req(2'd0, 32'h0000_0000, 32'd512, -1, 1'b1, "R10 ignore while busy");
        run_req(2'd3, 32'h0, 32'd1, -1, 1'b0, "R9 after ignore");

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0 && code_q.size() == 0, "R10 no stray activity",
            64'(exp_q.size() + code_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule